// File: doc/BRIEF.md
# Dual-Slope Converter Phase Sequencer

This block runs the analog phase sequence of an external dual-slope integrating converter front end. It drives a two-bit phase select and follows the comparator output through four phases: auto-zero, signal integrate, de-integrate against the reference, and integrator zero. All phase timing comes from a system tick that is the oscillator clock divided by a fixed ratio. The integrate window is set by a configuration byte and scaled by a binary prescaler.

The length of the de-integrate phase is counted in ticks and becomes the magnitude. The comparator level at the close of integration is kept as the polarity. A counter carry acts as a timeout. It marks the conversion overrange, clears the count and sends the front end straight back to auto-zero.

Each finished conversion is written into a result word of magnitude, overrange and polarity. A data-valid strobe is raised at the same time for the serial port block that follows. That strobe is dropped again as soon as the host starts a read or the enable input goes inactive.

Top module: `dss_seq`

## Requirements
- R1: After reset the phase output is 01 (auto-zero), the result word is all zeros and valid is low.
- R2: The phase codes are 00 integrator zero, 01 auto-zero, 10 integrate and 11 de-integrate. The order is auto-zero, integrate, de-integrate, integrator zero, auto-zero. The phase changes only on system ticks, and one tick occurs every DIV oscillator cycles.
- R3: The sequencer leaves auto-zero for integrate only on a tick where en_n is low. While en_n is high it stays in auto-zero. A conversion already past auto-zero runs to its end even if en_n rises.
- R4: Integrate lasts exactly (cfg_int+1)·2^PRE_W ticks. cfg_int is captured when integrate begins.
- R5: Bit CNT_W+1 of the result (polarity) holds the comparator level, after a two-flop synchronizer, at the final integrate tick.
- R6: De-integrate ends on the first tick where the synchronized comparator differs from the stored polarity. If that is the (M+1)-th tick after the one that entered de-integrate, then bits CNT_W-1:0 hold M, bit CNT_W (overrange) is 0, and the next phase is integrator zero.
- R7: If the count stands at 2^CNT_W−1 and the comparator has not changed at the next tick, the result gets overrange 1 and magnitude 0, and the next phase is auto-zero. A comparator change seen on that same tick wins and yields magnitude 2^CNT_W−1 with overrange 0.
- R8: Integrator zero lasts IZ_TICKS ticks and is followed by auto-zero. Auto-zero lasts AZ_TICKS ticks when en_n is low throughout.
- R9: Valid rises with the result update at the end of de-integrate when en_n and host_rd are both low. It is low in the cycle after any cycle in which en_n or host_rd is high. host_rd does not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low conversion enable |
| cfg_int | input | CFG_W | Integrate period setting |
| cmp_in | input | 1 | Asynchronous comparator output of the front end |
| host_rd | input | 1 | High while the host starts reading the result |
| phase | output | 2 | Phase select to the analog front end |
| result | output | CNT_W+2 | {polarity, overrange, magnitude} |
| valid | output | 1 | New result available |

## Verification
The hardest case to reach is the single tick at which the de-integrate count is at its last value. On that tick a comparator change has to beat the overflow carry. The stimulus detects entry into de-integrate at a falling edge and then waits an exact multiple of the tick period before it flips the comparator. The synchronizer delay fits inside one tick period, so a wait of N ticks produces magnitude N. With N one below the counter range, the change lands on the boundary tick. The bench also leaves the comparator still for a whole run to force the timeout path.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [1:0] {
    PH_IZ  = 2'b00,
    PH_AZ  = 2'b01,
    PH_INT = 2'b10,
    PH_DEI = 2'b11
  } phase_t;
endpackage

// File: rtl/dss_tick.sv
module dss_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst)               div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                   div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == LAST);

  // R2: ticks are isolated, never back to back
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/dss_sync.sv
module dss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= 1'b0;
        else     s_q <= d;
      end
      assign q = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= {s_q[STAGES-2:0], d};
      end
      assign q = s_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dss_int_timer.sv
module dss_int_timer #(
  parameter int PRE_W = 8,
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic             run,
  input  logic [CFG_W-1:0] cfg,
  output logic             last
);
  logic [PRE_W-1:0] pre_q;
  logic [CFG_W-1:0] maj_q;
  logic             pre_wrap;

  assign pre_wrap = &pre_q;
  assign last     = run && tick && pre_wrap && (maj_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      maj_q <= '0;
    end else if (start) begin
      pre_q <= '0;
      maj_q <= cfg;
    end else if (run && tick) begin
      pre_q <= pre_q + 1'b1;
      if (pre_wrap && (maj_q != '0)) maj_q <= maj_q - 1'b1;
    end
  end

  // R4: the period setting is captured when integrate is launched
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    start |=> (pre_q == '0) && (maj_q == $past(cfg)));
endmodule

// File: rtl/dss_seq.sv
module dss_seq #(
  parameter int DIV      = 4,
  parameter int CNT_W    = 16,
  parameter int PRE_W    = 8,
  parameter int CFG_W    = 8,
  parameter int AZ_TICKS = 16,
  parameter int IZ_TICKS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_n,
  input  logic [CFG_W-1:0]   cfg_int,
  input  logic               cmp_in,
  input  logic               host_rd,
  output logic [1:0]         phase,
  output logic [CNT_W+1:0]   result,
  output logic               valid
);
  import dss_pkg::*;

  localparam int DW_MAX = (AZ_TICKS > IZ_TICKS) ? AZ_TICKS : IZ_TICKS;
  localparam int DW_W   = $clog2(DW_MAX + 1);
  localparam logic [DW_W-1:0] AZ_LAST = DW_W'(AZ_TICKS - 1);
  localparam logic [DW_W-1:0] IZ_LAST = DW_W'(IZ_TICKS - 1);

  logic             tick;
  logic             cmp_s;
  logic             int_last;
  phase_t           phase_q;
  logic [DW_W-1:0]  dwell_q;
  logic [CNT_W-1:0] dcnt_q;
  logic [CNT_W:0]   dsum;
  logic             carry;
  logic             pol_q;
  logic [CNT_W+1:0] res_q;
  logic             valid_q;
  logic             az_go;
  logic             dei_flip;
  logic             done_w;

  dss_tick #(.DIV(DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  dss_sync #(.STAGES(2)) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (cmp_in),
    .q  (cmp_s)
  );

  assign az_go = tick && (phase_q == PH_AZ) && (dwell_q >= AZ_LAST) && !en_n;

  dss_int_timer #(.PRE_W(PRE_W), .CFG_W(CFG_W)) u_itmr (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .start(az_go),
    .run  (phase_q == PH_INT),
    .cfg  (cfg_int),
    .last (int_last)
  );

  assign dsum     = {1'b0, dcnt_q} + 1'b1;
  assign carry    = dsum[CNT_W];
  assign dei_flip = (cmp_s != pol_q);
  assign done_w   = tick && (phase_q == PH_DEI) && (dei_flip || carry);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_AZ;
      dwell_q <= '0;
      dcnt_q  <= '0;
      pol_q   <= 1'b0;
      res_q   <= '0;
    end else if (tick) begin
      case (phase_q)
        PH_IZ: begin
          if (dwell_q == IZ_LAST) begin
            phase_q <= PH_AZ;
            dwell_q <= '0;
          end else begin
            dwell_q <= dwell_q + 1'b1;
          end
        end
        PH_AZ: begin
          if (az_go) begin
            phase_q <= PH_INT;
            dwell_q <= '0;
          end else if (dwell_q < AZ_LAST) begin
            dwell_q <= dwell_q + 1'b1;
          end
        end
        PH_INT: begin
          if (int_last) begin
            phase_q <= PH_DEI;
            pol_q   <= cmp_s;
            dcnt_q  <= '0;
          end
        end
        default: begin
          if (dei_flip) begin
            res_q   <= {pol_q, 1'b0, dcnt_q};
            phase_q <= PH_IZ;
            dwell_q <= '0;
          end else if (carry) begin
            res_q   <= {pol_q, 1'b1, {CNT_W{1'b0}}};
            phase_q <= PH_AZ;
            dcnt_q  <= '0;
            dwell_q <= '0;
          end else begin
            dcnt_q <= dsum[CNT_W-1:0];
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   valid_q <= 1'b0;
    else if (en_n || host_rd)  valid_q <= 1'b0;
    else if (done_w)           valid_q <= 1'b1;
  end

  assign phase  = phase_q;
  assign result = res_q;
  assign valid  = valid_q;

  // R2: phase moves only on a system tick
  a_r2_tick_only: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(phase_q));

  // R3: disabled converter never enters integrate from auto-zero
  a_r3_hold_az: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_AZ && en_n) |=> (phase_q != PH_INT));

  // R2: integrate is left only for de-integrate
  a_r2_int_exit: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_INT) |=> (phase_q == PH_INT || phase_q == PH_DEI));

  // R7: an overrange result carries a cleared magnitude
  a_r7_ovr_zero: assert property (@(posedge clk) disable iff (rst)
    res_q[CNT_W] |-> (res_q[CNT_W-1:0] == '0));

  // R9: read start or disable drops valid
  a_r9_valid_clr: assert property (@(posedge clk) disable iff (rst)
    (en_n || host_rd) |=> !valid_q);

  // R9: host reads leave the result untouched
  a_r9_rd_keep: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !done_w) |=> $stable(res_q));
endmodule

// File: tb/sim_dss_seq.sv
module sim_dss_seq;
  localparam int DIV   = 4;
  localparam int CNT_W = 8;
  localparam int PRE_W = 4;
  localparam int CFG_W = 8;
  localparam int AZT   = 4;
  localparam int IZT   = 3;

  logic             clk = 1'b0;
  logic             rst;
  logic             en_n;
  logic [CFG_W-1:0] cfg_int;
  logic             cmp;
  logic             host_rd;
  logic [1:0]       phase;
  logic [CNT_W+1:0] result;
  logic             valid;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  dss_seq #(.DIV(DIV), .CNT_W(CNT_W), .PRE_W(PRE_W), .CFG_W(CFG_W),
            .AZ_TICKS(AZT), .IZ_TICKS(IZT)) u0 (
    .clk(clk), .rst(rst), .en_n(en_n), .cfg_int(cfg_int), .cmp_in(cmp),
    .host_rd(host_rd), .phase(phase), .result(result), .valid(valid)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int res_word(input bit pol, input bit ovr, input int mag);
    return (int'(pol) << (CNT_W + 1)) | (int'(ovr) << CNT_W) | mag;
  endfunction

  task automatic count_while(input logic [1:0] ph, output int n);
    n = 0;
    while (phase == ph && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_phase(input logic [1:0] ph);
    int g = 0;
    while (phase != ph && g < 20000) begin
      g++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk(int'(phase), 1, "R1 phase");
    chk(int'(result), 0, "R1 result");
    chk(int'(valid), 0, "R1 valid");
  endtask

  task automatic t_disabled;
    int moved = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (phase != 2'b01) moved++;
    end
    chk(moved, 0, "R3 held in auto-zero");
    chk(int'(valid), 0, "R9 valid while disabled");
  endtask

  // starts in auto-zero with en_n high; ends in auto-zero with en_n high
  task automatic t_convert(input int cfg, input bit pol, input int n, input bit rd);
    int c;
    cmp = pol;
    cfg_int = CFG_W'(cfg);
    @(negedge clk);
    en_n = 1'b0;
    wait_phase(2'b10);
    count_while(2'b10, c);
    chk(c, (cfg + 1) * (1 << PRE_W) * DIV, "R4 integrate length");
    chk(int'(phase), 3, "R2 integrate to de-integrate");
    cfg_int = '1;
    repeat (DIV * n) @(negedge clk);
    cmp = !pol;
    count_while(2'b11, c);
    chk(int'(phase), 0, "R6 de-integrate to integrator zero");
    chk(int'(result), res_word(pol, 1'b0, n), "R6 magnitude");
    chk(int'(result[CNT_W+1]), int'(pol), "R5 polarity");
    chk(int'(valid), 1, "R9 valid raised");
    if (rd) begin
      host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
      chk(int'(valid), 0, "R9 valid dropped by read");
      chk(int'(result), res_word(pol, 1'b0, n), "R9 result kept on read");
    end
    count_while(2'b00, c);
    chk(c, IZT * DIV - (rd ? 1 : 0), "R8 integrator zero length");
    chk(int'(phase), 1, "R2 integrator zero to auto-zero");
    en_n = 1'b1;
    @(negedge clk);
    chk(int'(valid), 0, "R9 valid dropped by disable");
  endtask

  task automatic t_overflow(input bit pol);
    int c;
    cmp = pol;
    cfg_int = '0;
    @(negedge clk);
    en_n = 1'b0;
    wait_phase(2'b10);
    count_while(2'b10, c);
    count_while(2'b11, c);
    en_n = 1'b1;
    chk(c, (1 << CNT_W) * DIV, "R7 timeout length");
    chk(int'(phase), 1, "R7 timeout to auto-zero");
    chk(int'(result), res_word(pol, 1'b1, 0), "R7 overrange word");
    chk(int'(valid), 1, "R9 valid on overrange");
  endtask

  task automatic t_dwell;
    int c;
    cmp = 1'b0;
    cfg_int = '0;
    @(negedge clk);
    en_n = 1'b0;
    wait_phase(2'b10);
    count_while(2'b10, c);
    cmp = 1'b1;
    count_while(2'b11, c);
    count_while(2'b00, c);
    count_while(2'b01, c);
    chk(c, AZT * DIV, "R8 auto-zero length");
    chk(int'(phase), 2, "R2 auto-zero to integrate");
    @(negedge clk);
    en_n = 1'b1;
    wait_phase(2'b11);
    wait_phase(2'b01);
    chk(int'(result), res_word(1'b1, 1'b1, 0), "R3 conversion finished after disable");
    chk(int'(valid), 0, "R9 no valid while disabled");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    en_n = 1'b1;
    cmp = 1'b0;
    host_rd = 1'b0;
    cfg_int = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_convert(2, 1'b1, 5, 1'b0);
    t_convert(0, 1'b0, 0, 1'b1);
    t_convert(1, 1'b0, 37, 1'b0);
    t_convert(0, 1'b1, (1 << CNT_W) - 1, 1'b0);
    t_overflow(1'b0);
    t_overflow(1'b1);
    t_dwell();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule